// File: doc/BRIEF.md
# Clock Frequency Monitor

This block watches a monitored clock and compares its rate against a reference clock. It opens a measurement window that lasts a set number of ticks of a prescaled reference clock. During that window it counts rising edges of the monitored clock, then checks the count against a programmed tolerance band. A count outside the band raises a mismatch flag. A count of zero raises a loss-of-clock flag. Both flags stay set until they are cleared.

The monitored edge count is kept in the monitored clock domain as a Gray-coded counter. It is synchronised into the reference domain. The window opens and closes on samples of this synchronised count. A run starts when `enable` rises.

In single-shot mode the unit measures one window and then parks in a finished state. In periodic mode it lets a programmed number of idle windows pass between measurements and repeats without end. An interrupt line combines the flags with an interrupt enable. A two-bit cause code reports the more urgent flag. The design assumes the monitored clock runs slower than the reference clock, so the synchronised Gray count moves by at most one step per reference cycle.

Top module: `clk_freq_monitor`

## Requirements
- R1: After reset, `loc`, `mis`, `irq`, `busy`, `done`, `win_end` are 0, `cause` is 0 and `last_count` is 0.
- R2: A window lasts (`win_len`+2)×2^`ref_div` reference cycles. `last_count` is set to the number of monitored rising edges in that window, within ±1.
- R3: At the end of a window, `mis` is set if the count is below `cnt_min` or above `cnt_max`. Both limits are inclusive, so a count equal to a limit does not set `mis`.
- R4: At the end of a window, `loc` is set if the count is zero. `cause` is 2 when `loc` is set, else 1 when `mis` is set, else 0.
- R5: `irq` is 1 exactly when `irq_en` is 1 and at least one of `loc`, `mis` is set.
- R6: A one-cycle pulse on `clr_loc` clears only `loc`, and a pulse on `clr_mis` clears only `mis`. A flag being set in the same cycle wins over the clear.
- R7: While `enable` is 0, the unit is idle: `busy` and `done` are 0, and both flags are cleared one cycle after `enable` falls.
- R8: With `per_en` at 0, exactly one `win_end` pulse occurs per run. `done` then stays 1 and `busy` is 0 until `enable` falls.
- R9: With `per_en` at 1, `win_end` pulses repeat every (1+`per_gap`)×(`win_len`+2)×2^`ref_div` reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset, reference domain |
| mon_clk | input | 1 | Clock under observation |
| mon_rst_n | input | 1 | Synchronous active-low reset, monitored domain |
| enable | input | 1 | Starts a run on rise; low returns to idle and clears flags |
| irq_en | input | 1 | Interrupt enable |
| ref_div | input | 4 | Reference prescale exponent (divide by 2^ref_div) |
| win_len | input | 24 | Window length in prescaled ticks, minus 2 |
| cnt_min | input | 24 | Lowest acceptable count |
| cnt_max | input | 24 | Highest acceptable count |
| per_en | input | 1 | Periodic mode select |
| per_gap | input | 4 | Idle windows between periodic measurements |
| clr_loc | input | 1 | Write-one clear of the loss-of-clock flag |
| clr_mis | input | 1 | Write-one clear of the mismatch flag |
| loc | output | 1 | Loss-of-clock flag |
| mis | output | 1 | Frequency mismatch flag |
| cause | output | 2 | 2 = loss of clock, 1 = mismatch, 0 = none |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A measurement window is open |
| done | output | 1 | Single-shot run finished |
| win_end | output | 1 | One-cycle pulse when a window completes |
| last_count | output | 24 | Count from the latest completed window |

## Verification
The bench runs a table of prescale and window settings against monitored periods that land below, inside and above the band. A prescaler that ignores the exponent or a window one tick short would move the count out of its ±1 tolerance. A stopped monitored clock with a zero lower limit shows whether loss of clock is kept separate from mismatch. With a nonzero limit it shows that the cause code puts loss of clock first. Separate clears, interrupt gating, flag clearing on disable and exact periodic spacing are each measured at the ports. A design that cleared both flags together, left flags set after disable, or miscounted idle windows would show up directly in these checks.

// File: rtl/cfm_pkg.sv
// Shared types for the clock frequency monitor.
package cfm_pkg;
    // Controller states: idle, counting window, idle gap windows, finished
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } cfm_state_t;

    localparam logic [1:0] CAUSE_NONE = 2'd0;
    localparam logic [1:0] CAUSE_MIS  = 2'd1;
    localparam logic [1:0] CAUSE_LOC  = 2'd2;
endpackage

// File: rtl/cfm_prescaler.sv
// Reference prescaler: emits a one-cycle tick every 2^div reference cycles
// while run is high. Assumes div is stable during a run; restarts from zero
// whenever run is low.
module cfm_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PC_W = (1 << DIV_W) - 1;

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] mask;

    // Terminal value of the prescale counter for the chosen exponent
    always_comb begin
        mask = {PC_W{1'b1}} >> (PC_W - int'(div));
        tick = run && (pc == mask);
    end

    // Prescale counter, wraps at mask
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pc <= '0;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div != '0 && tick) |=> !tick)
        else $error("prescaler ticked on consecutive cycles");
endmodule

// File: rtl/cfm_gray_sync.sv
// Monitored-edge counter and crossing: counts mon_clk rising edges in a
// Gray-coded register, then double-flops it into the reference domain and
// converts it back to binary. Assumes mon_clk is slower than ref_clk.
module cfm_gray_sync #(
    parameter int CNT_W = 24
) (
    input  logic             mon_clk,
    input  logic             mon_rst_n,
    input  logic             ref_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] mon_bin
);
    logic [CNT_W-1:0] bin_m;
    logic [CNT_W-1:0] bin_m_nx;
    logic [CNT_W-1:0] gray_m;
    logic [CNT_W-1:0] g_s1;
    logic [CNT_W-1:0] g_s2;

    assign bin_m_nx = bin_m + 1'b1;

    // Binary and Gray counters in the monitored domain
    always_ff @(posedge mon_clk) begin
        if (!mon_rst_n) begin
            bin_m  <= '0;
            gray_m <= '0;
        end else begin
            bin_m  <= bin_m_nx;
            gray_m <= bin_m_nx ^ (bin_m_nx >> 1);
        end
    end

    // Two-flop synchroniser into the reference domain
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            g_s1 <= '0;
            g_s2 <= '0;
        end else begin
            g_s1 <= gray_m;
            g_s2 <= g_s1;
        end
    end

    // Gray to binary conversion
    always_comb begin
        mon_bin[CNT_W-1] = g_s2[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            mon_bin[i] = mon_bin[i+1] ^ g_s2[i];
        end
    end

    // R2
    gray_step_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (g_s2 != $past(g_s2)) |-> ($countones(g_s2 ^ $past(g_s2)) == 1))
        else $error("synchronised Gray count moved by more than one step");
endmodule

// File: rtl/cfm_ctrl.sv
// Window controller: sequences measure and gap windows on prescaled ticks,
// captures the edge count at each window end and keeps the sticky flags.
// Assumes configuration inputs are stable while enable is high.
module cfm_ctrl
    import cfm_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int WIN_W = 24,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] mon_bin,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] cnt_min,
    input  logic [CNT_W-1:0] cnt_max,
    input  logic             per_en,
    input  logic [GAP_W-1:0] per_gap,
    input  logic             clr_loc,
    input  logic             clr_mis,
    output logic             running,
    output logic             busy,
    output logic             done,
    output logic             win_end,
    output logic             loc,
    output logic             mis,
    output logic [CNT_W-1:0] last_count
);
    cfm_state_t       state;
    logic [WIN_W:0]   wcnt;
    logic [GAP_W-1:0] gcnt;
    logic [CNT_W-1:0] start_cnt;
    logic [CNT_W-1:0] delta;
    logic             last_tick;
    logic             gap_last;
    logic             loc_q;
    logic             mis_q;
    logic             win_end_q;

    // Window end detection and edge delta
    always_comb begin
        last_tick = (wcnt == ({1'b0, win_len} + {{WIN_W{1'b0}}, 1'b1}));
        gap_last  = (gcnt == (per_gap - {{(GAP_W-1){1'b0}}, 1'b1}));
        delta     = mon_bin - start_cnt;
    end

    // Sequencer, count capture and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wcnt       <= '0;
            gcnt       <= '0;
            start_cnt  <= '0;
            last_count <= '0;
            loc_q      <= 1'b0;
            mis_q      <= 1'b0;
            win_end_q  <= 1'b0;
        end else if (!enable) begin
            state     <= ST_IDLE;
            wcnt      <= '0;
            gcnt      <= '0;
            loc_q     <= 1'b0;
            mis_q     <= 1'b0;
            win_end_q <= 1'b0;
        end else begin
            win_end_q <= 1'b0;
            if (clr_loc) loc_q <= 1'b0;
            if (clr_mis) mis_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    state     <= ST_MEAS;
                    wcnt      <= '0;
                    start_cnt <= mon_bin;
                end
                ST_MEAS: begin
                    if (tick) begin
                        if (last_tick) begin
                            wcnt       <= '0;
                            gcnt       <= '0;
                            last_count <= delta;
                            win_end_q  <= 1'b1;
                            if (delta == '0) loc_q <= 1'b1;
                            if (delta < cnt_min || delta > cnt_max) mis_q <= 1'b1;
                            if (!per_en) begin
                                state <= ST_DONE;
                            end else if (per_gap == '0) begin
                                start_cnt <= mon_bin;
                            end else begin
                                state <= ST_GAP;
                            end
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (last_tick) begin
                            wcnt <= '0;
                            if (gap_last) begin
                                state     <= ST_MEAS;
                                start_cnt <= mon_bin;
                            end else begin
                                gcnt <= gcnt + 1'b1;
                            end
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    assign running = (state == ST_MEAS) || (state == ST_GAP);
    assign busy    = (state == ST_MEAS);
    assign done    = (state == ST_DONE);
    assign win_end = win_end_q;
    assign loc     = loc_q;
    assign mis     = mis_q;

    // R4
    loc_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_q) |-> win_end_q)
        else $error("loss-of-clock flag rose outside a window end");

    // R3
    mis_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mis_q) |-> win_end_q)
        else $error("mismatch flag rose outside a window end");

    // R7
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!loc_q && !mis_q && state == ST_IDLE))
        else $error("flags or state survived a disable");

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> !win_end_q)
        else $error("window ended after single-shot completion");
endmodule

// File: rtl/clk_freq_monitor.sv
// Clock frequency monitor top: joins the prescaler, the monitored-count
// crossing and the window controller; forms the cause code and interrupt.
// Assumes mon_clk is slower than ref_clk and configuration is held stable
// while enable is high.
module clk_freq_monitor
    import cfm_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int WIN_W = 24,
    parameter int CNT_W = 24,
    parameter int GAP_W = 4
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic             mon_rst_n,
    input  logic             enable,
    input  logic             irq_en,
    input  logic [DIV_W-1:0] ref_div,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] cnt_min,
    input  logic [CNT_W-1:0] cnt_max,
    input  logic             per_en,
    input  logic [GAP_W-1:0] per_gap,
    input  logic             clr_loc,
    input  logic             clr_mis,
    output logic             loc,
    output logic             mis,
    output logic [1:0]       cause,
    output logic             irq,
    output logic             busy,
    output logic             done,
    output logic             win_end,
    output logic [CNT_W-1:0] last_count
);
    logic             running;
    logic             tick;
    logic [CNT_W-1:0] mon_bin;

    cfm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .run   (running),
        .div   (ref_div),
        .tick  (tick)
    );

    cfm_gray_sync #(.CNT_W(CNT_W)) u_sync (
        .mon_clk   (mon_clk),
        .mon_rst_n (mon_rst_n),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .mon_bin   (mon_bin)
    );

    cfm_ctrl #(.CNT_W(CNT_W), .WIN_W(WIN_W), .GAP_W(GAP_W)) u_ctrl (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .mon_bin    (mon_bin),
        .win_len    (win_len),
        .cnt_min    (cnt_min),
        .cnt_max    (cnt_max),
        .per_en     (per_en),
        .per_gap    (per_gap),
        .clr_loc    (clr_loc),
        .clr_mis    (clr_mis),
        .running    (running),
        .busy       (busy),
        .done       (done),
        .win_end    (win_end),
        .loc        (loc),
        .mis        (mis),
        .last_count (last_count)
    );

    // Cause code with loss of clock ranked first, and gated interrupt
    always_comb begin
        if (loc)      cause = CAUSE_LOC;
        else if (mis) cause = CAUSE_MIS;
        else          cause = CAUSE_NONE;
        irq = irq_en && (loc || mis);
    end

    // R8
    busy_done_excl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(busy && done))
        else $error("busy and done both high");
endmodule

// File: tb/sim_clk_freq_monitor.sv
module sim_clk_freq_monitor;
    localparam int REF_PERIOD = 10;
    localparam int NV = 6;

    typedef struct packed {
        logic [3:0]  div;
        logic [23:0] win;
        logic [23:0] mn;
        logic [23:0] mx;
        logic [7:0]  mh;
        logic        em;
    } vec_t;

    // div, win_len, min, max, monitored half period, expected mismatch
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd0, 24'd98,  24'd30, 24'd50,  8'd13, 1'b0},
        '{4'd1, 24'd48,  24'd30, 24'd50,  8'd13, 1'b0},
        '{4'd2, 24'd23,  24'd30, 24'd50,  8'd20, 1'b1},
        '{4'd0, 24'd198, 24'd40, 24'd100, 8'd9,  1'b1},
        '{4'd3, 24'd10,  24'd30, 24'd45,  8'd13, 1'b0},
        '{4'd0, 24'd38,  24'd10, 24'd30,  8'd10, 1'b0}
    };

    logic        ref_clk = 1'b0;
    logic        mon_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mon_rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        irq_en = 1'b0;
    logic [3:0]  ref_div = '0;
    logic [23:0] win_len = '0;
    logic [23:0] cnt_min = '0;
    logic [23:0] cnt_max = '0;
    logic        per_en = 1'b0;
    logic [3:0]  per_gap = '0;
    logic        clr_loc = 1'b0;
    logic        clr_mis = 1'b0;
    logic        loc, mis, irq, busy, done, win_end;
    logic [1:0]  cause;
    logic [23:0] last_count;

    int  mon_half = 13;
    bit  mon_run = 1'b1;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    clk_freq_monitor u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .mon_rst_n(mon_rst_n),
        .enable(enable), .irq_en(irq_en), .ref_div(ref_div), .win_len(win_len),
        .cnt_min(cnt_min), .cnt_max(cnt_max), .per_en(per_en), .per_gap(per_gap),
        .clr_loc(clr_loc), .clr_mis(clr_mis), .loc(loc), .mis(mis), .cause(cause),
        .irq(irq), .busy(busy), .done(done), .win_end(win_end), .last_count(last_count)
    );

    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    always begin
        #(mon_half);
        if (mon_run) mon_clk = ~mon_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    // Waits for done, counting win_end pulses, then a quiet stretch
    task automatic wait_done(output int pulses);
        int guard;
        pulses = 0;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge ref_clk);
            if (win_end) pulses++;
            guard++;
        end
        for (int i = 0; i < 60; i++) begin
            @(negedge ref_clk);
            if (win_end) pulses++;
        end
    endtask

    // Returns cycle index of next win_end pulse
    task automatic next_end(inout int t);
        int guard;
        guard = 0;
        @(negedge ref_clk);
        t++;
        while (!win_end && guard < 5000) begin
            @(negedge ref_clk);
            t++;
            guard++;
        end
    endtask

    initial begin
        #(REF_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int pulses;
        int expc;
        int len;
        int t, t1, t2, t3;

        cyc(6);
        rst_n = 1'b1;
        mon_rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(!loc && !mis && !irq && !busy && !done && !win_end, "R1 flags", {loc, mis, irq, busy, done, win_end}, 0);
        chk(cause == 2'd0 && last_count == '0, "R1 count", int'(last_count), 0);

        // Table walk: R2 count, R3 band, R8 single shot
        for (int v = 0; v < NV; v++) begin
            ref_div  = VECS[v].div;
            win_len  = VECS[v].win;
            cnt_min  = VECS[v].mn;
            cnt_max  = VECS[v].mx;
            mon_half = int'(VECS[v].mh);
            per_en   = 1'b0;
            cyc(4);
            enable = 1'b1;
            wait_done(pulses);
            len  = (int'(VECS[v].win) + 2) << VECS[v].div;
            expc = (len * REF_PERIOD) / (2 * int'(VECS[v].mh));
            chk(int'(last_count) >= expc - 1 && int'(last_count) <= expc + 1, "R2 count", int'(last_count), expc);
            chk(mis == VECS[v].em, "R3 band", int'(mis), int'(VECS[v].em));
            chk(!loc, "R4 no loc", int'(loc), 0);
            chk(done && !busy && pulses == 1, "R8 single", pulses, 1);
            enable = 1'b0;
            cyc(2);
        end

        // Stopped clock, zero lower limit: loc only (R4)
        mon_run = 1'b0;
        cyc(20);
        ref_div = 4'd0; win_len = 24'd20; cnt_min = 24'd0; cnt_max = 24'd50;
        irq_en = 1'b1;
        enable = 1'b1;
        wait_done(pulses);
        chk(loc && !mis && last_count == '0, "R4 loc only", {loc, mis}, 2);
        chk(cause == 2'd2 && irq, "R4 cause loc", int'(cause), 2);
        enable = 1'b0;
        cyc(2);

        // Stopped clock, nonzero lower limit: both flags, loc first (R4, R5)
        cnt_min = 24'd5;
        enable = 1'b1;
        wait_done(pulses);
        chk(loc && mis, "R4 both", {loc, mis}, 3);
        chk(cause == 2'd2, "R4 priority", int'(cause), 2);
        chk(irq, "R5 irq on", int'(irq), 1);
        irq_en = 1'b0;
        cyc(1);
        chk(!irq, "R5 irq gated", int'(irq), 0);
        irq_en = 1'b1;
        // R6 separate clears
        clr_loc = 1'b1;
        cyc(1);
        clr_loc = 1'b0;
        cyc(1);
        chk(!loc && mis && cause == 2'd1, "R6 clr loc", {loc, mis}, 1);
        clr_mis = 1'b1;
        cyc(1);
        clr_mis = 1'b0;
        cyc(1);
        chk(!loc && !mis && cause == 2'd0 && !irq, "R6 clr mis", {loc, mis, irq}, 0);
        enable = 1'b0;
        mon_run = 1'b1;
        cyc(4);

        // R7 disable clears flags
        mon_half = 20; ref_div = 4'd0; win_len = 24'd98; cnt_min = 24'd40; cnt_max = 24'd60;
        cyc(2);
        enable = 1'b1;
        wait_done(pulses);
        chk(mis, "R7 setup mis", int'(mis), 1);
        enable = 1'b0;
        cyc(1);
        chk(!mis && !loc && !busy && !done, "R7 cleared", {loc, mis, busy, done}, 0);

        // R9 periodic spacing with gap of two windows
        mon_half = 13; ref_div = 4'd1; win_len = 24'd4; per_en = 1'b1; per_gap = 4'd2;
        cnt_min = 24'd0; cnt_max = 24'd100;
        cyc(2);
        enable = 1'b1;
        t = 0;
        next_end(t); t1 = t;
        next_end(t); t2 = t;
        next_end(t); t3 = t;
        chk(t2 - t1 == 36, "R9 gap2 a", t2 - t1, 36);
        chk(t3 - t2 == 36, "R9 gap2 b", t3 - t2, 36);
        chk(!done, "R9 no done", int'(done), 0);
        enable = 1'b0;
        cyc(2);

        // R9 back-to-back windows
        per_gap = 4'd0;
        enable = 1'b1;
        t = 0;
        next_end(t); t1 = t;
        next_end(t); t2 = t;
        chk(t2 - t1 == 12, "R9 gap0", t2 - t1, 12);
        chk(busy, "R9 busy", int'(busy), 1);
        enable = 1'b0;
        cyc(2);

        finish_run();
    end
endmodule